// File: doc/BRIEF.md
# Frame Buffer Pixel Unpacker

This block takes 32-bit words read from a frame buffer or a palette buffer and turns them into a stream of output beats in display order. Each beat holds one pixel, one palette entry, or a group of 1-bit monochrome pixels. A two-bit depth setting chooses between 1-bit monochrome, 4-bit, 8-bit and 16-bit elements. A byte-order setting chooses whether extraction starts at the least significant or the most significant end of the word. In monochrome mode, a dual-width setting chooses whether each beat carries four or eight pixels.

Words enter through a valid/ready handshake. The output is a 16-bit data bus with a valid flag and has no back-pressure, so one beat leaves on every cycle while a word is being unpacked. The input is ready again during the last beat of a word, which lets a stream of words flow with no idle cycle between them. The configuration inputs are captured together with each word, so a change takes effect only at a word boundary. Palette lookup, fetching, panel timing and dithering are outside this block.

Top module: `fb_unpacker`

## Requirements
- R1: After reset, `in_ready` is 1 and `pix_valid` is 0.
- R2: With depth 2'b01 (4-bit) and `cfg_msb_first`=0, eight beats come out. Beat i carries word bits [4i+3:4i], so the least significant nibble comes first.
- R3: With depth 2'b01 and `cfg_msb_first`=1, eight beats come out and the most significant nibble comes first. Beat i carries bits [31-4i:28-4i].
- R4: With depth 2'b10 (8-bit), four beats come out. The least significant byte comes first when `cfg_msb_first`=0 and the most significant byte comes first when it is 1.
- R5: With depth 2'b11 (16-bit, also used for palette entries), two beats come out. The low half-word comes first when `cfg_msb_first`=0 and the high half-word comes first when it is 1.
- R6: With depth 2'b00 (monochrome) and `cfg_dual`=0, eight beats of four pixels come out, taken as 4-bit groups in the selected byte order. `pix_data[15:4]` is 0.
- R7: With depth 2'b00 and `cfg_dual`=1, four beats of eight pixels come out, taken as 8-bit groups in the selected byte order. `pix_data[15:8]` is 0.
- R8: `cfg_dual` has no effect when the depth is anything other than 2'b00.
- R9: While a word still has beats left after the current one, `in_ready` is 0, and a word offered on `in_word` is neither taken nor seen at the output. `in_ready` is 1 during the last beat, so the next word's first beat follows with no gap.
- R10: Depth, byte order and dual settings are captured when a word is accepted. Changing them in the middle of a word does not alter that word's beats.
- R11: The first beat appears in the cycle after the handshake. `pix_valid` is 1 for exactly the beat count of the word and is 0 when no word is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_depth | input | 2 | Element size: 00 mono, 01 4-bit, 10 8-bit, 11 16-bit |
| cfg_msb_first | input | 1 | 1 = extract from the most significant end first |
| cfg_dual | input | 1 | Monochrome only: 1 = eight pixels per beat |
| in_word | input | 32 | Fetched buffer word |
| in_valid | input | 1 | `in_word` is offered |
| in_ready | output | 1 | Unpacker can take a word this cycle |
| pix_data | output | 16 | Current beat, zero-extended |
| pix_valid | output | 1 | `pix_data` holds a beat |

## Verification
Four properties are checked on every cycle:
- The held word and its captured settings stay frozen until the last beat.
- `in_ready` stays low while beats remain.
- The beat index never passes the last beat of the current depth.
- Unused upper output bits stay zero.

The actual extraction order for each depth and byte order, the no-gap hand-over between words, the inertness of the dual setting outside monochrome, and the effect of a mid-word configuration change on the output can only be shown by the bench's directed scenarios. Those scenarios compare every beat against values computed from the requirements.

// File: rtl/fbu_pkg.sv
package fbu_pkg;

    typedef enum logic [1:0] {
        DEPTH_MONO = 2'b00,
        DEPTH_NIB  = 2'b01,
        DEPTH_BYTE = 2'b10,
        DEPTH_HALF = 2'b11
    } depth_e;

    // log2 of the beat width in bits for a depth / dual pair
    function automatic logic [2:0] beat_lg(input logic [1:0] depth, input logic dual);
        case (depth)
            DEPTH_MONO: beat_lg = dual ? 3'd3 : 3'd2;
            DEPTH_NIB:  beat_lg = 3'd2;
            DEPTH_BYTE: beat_lg = 3'd3;
            default:    beat_lg = 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/fbu_seq.sv
module fbu_seq
    import fbu_pkg::*;
#(
    parameter int WORD_W = 32,
    localparam int IDX_W = $clog2(WORD_W / 4)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_msb_first,
    input  logic              cfg_dual,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic              busy,
    output logic [WORD_W-1:0] word,
    output logic [IDX_W-1:0]  idx,
    output logic [2:0]        lg,
    output logic              msb_first
);

    typedef struct packed {
        logic              busy;
        logic [IDX_W-1:0]  idx;
        logic [WORD_W-1:0] word;
        logic [1:0]        depth;
        logic              msb;
        logic              dual;
    } seq_t;

    seq_t st_d, st_q;
    logic [2:0]       lg_q;
    logic [IDX_W-1:0] last_idx;
    logic             at_last;
    logic             accept;

    always_comb begin
        lg_q     = beat_lg(st_q.depth, st_q.dual);
        last_idx = IDX_W'((WORD_W >> lg_q) - 1);
        at_last  = st_q.busy && (st_q.idx == last_idx);
        in_ready = !st_q.busy || at_last;
        accept   = in_valid && in_ready;

        st_d = st_q;
        if (st_q.busy) begin
            if (at_last) st_d.busy = 1'b0;
            else         st_d.idx  = st_q.idx + 1'b1;
        end
        if (accept) begin
            st_d.busy  = 1'b1;
            st_d.idx   = '0;
            st_d.word  = in_word;
            st_d.depth = cfg_depth;
            st_d.msb   = cfg_msb_first;
            st_d.dual  = cfg_dual;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy      = st_q.busy;
    assign word      = st_q.word;
    assign idx       = st_q.idx;
    assign lg        = lg_q;
    assign msb_first = st_q.msb;

    assert_hold_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !at_last) |=> (st_q.busy && $stable(st_q.word)));

    assert_no_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !at_last) |-> !in_ready);

    assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && !at_last) |=> ($stable(st_q.depth) && $stable(st_q.msb) && $stable(st_q.dual)));

    assert_idx_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.busy |-> (st_q.idx <= last_idx));

endmodule

// File: rtl/fbu_lane_mux.sv
module fbu_lane_mux #(
    parameter int WORD_W = 32,
    parameter int OUT_W  = 16,
    localparam int IDX_W = $clog2(WORD_W / 4)
) (
    input  logic [WORD_W-1:0] word,
    input  logic [IDX_W-1:0]  idx,
    input  logic [2:0]        lg,
    input  logic              msb_first,
    output logic [OUT_W-1:0]  lane
);

    logic [IDX_W-1:0]  last_idx;
    logic [IDX_W-1:0]  pos;
    logic [WORD_W-1:0] shifted;
    logic [OUT_W-1:0]  mask;

    always_comb begin
        last_idx = IDX_W'((WORD_W >> lg) - 1);
        pos      = msb_first ? (last_idx - idx) : idx;
        shifted  = word >> ({{(32-IDX_W){1'b0}}, pos} << lg);
        mask     = OUT_W'((33'd1 << (33'd1 << lg)) - 33'd1);
        lane     = shifted[OUT_W-1:0] & mask;
    end

endmodule

// File: rtl/fb_unpacker.sv
module fb_unpacker
    import fbu_pkg::*;
#(
    parameter int WORD_W = 32,
    parameter int OUT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_depth,
    input  logic              cfg_msb_first,
    input  logic              cfg_dual,
    input  logic [WORD_W-1:0] in_word,
    input  logic              in_valid,
    output logic              in_ready,
    output logic [OUT_W-1:0]  pix_data,
    output logic              pix_valid
);

    localparam int IDX_W = $clog2(WORD_W / 4);

    logic              busy;
    logic [WORD_W-1:0] word;
    logic [IDX_W-1:0]  idx;
    logic [2:0]        lg;
    logic              msb_first;

    fbu_seq #(.WORD_W(WORD_W)) u_seq (
        .clk(clk), .rst_n(rst_n),
        .cfg_depth(cfg_depth), .cfg_msb_first(cfg_msb_first), .cfg_dual(cfg_dual),
        .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .busy(busy), .word(word), .idx(idx), .lg(lg), .msb_first(msb_first)
    );

    fbu_lane_mux #(.WORD_W(WORD_W), .OUT_W(OUT_W)) u_mux (
        .word(word), .idx(idx), .lg(lg), .msb_first(msb_first), .lane(pix_data)
    );

    assign pix_valid = busy;

    assert_first_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> pix_valid);

    assert_pad_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && lg != 3'd4) |-> (pix_data[OUT_W-1:8] == '0));

    assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !pix_valid |-> in_ready);

endmodule

// File: tb/fb_unpacker_test.sv
module fb_unpacker_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_depth = 2'b00;
    logic        cfg_msb_first = 1'b0;
    logic        cfg_dual = 1'b0;
    logic [31:0] in_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] pix_data;
    logic        pix_valid;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    fb_unpacker uut (
        .clk(clk), .rst_n(rst_n), .cfg_depth(cfg_depth), .cfg_msb_first(cfg_msb_first),
        .cfg_dual(cfg_dual), .in_word(in_word), .in_valid(in_valid), .in_ready(in_ready),
        .pix_data(pix_data), .pix_valid(pix_valid)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int width_of(input logic [1:0] d, input logic dl);
        case (d)
            2'b00: return dl ? 8 : 4;
            2'b01: return 4;
            2'b10: return 8;
            default: return 16;
        endcase
    endfunction

    function automatic logic [15:0] expect_beat(input logic [31:0] w, input int wd, input logic msb, input int i);
        int n = 32 / wd;
        int p = msb ? (n - 1 - i) : i;
        logic [31:0] m = (32'd1 << wd) - 1;
        return 16'((w >> (p * wd)) & m);
    endfunction

    task automatic expect_word(input string tag, input logic [31:0] w, input int wd, input logic msb);
        int n = 32 / wd;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check({tag, " valid"}, 32'(pix_valid), 32'd1);
            check({tag, " data"}, 32'(pix_data), 32'(expect_beat(w, wd, msb, i)));
            check({tag, " ready"}, 32'(in_ready), 32'(i == n - 1));
        end
    endtask

    // one word, settings optionally changed right after acceptance (R10)
    task automatic run_word(input string tag, input logic [31:0] w, input logic [1:0] d,
                            input logic msb, input logic dl, input bit scramble);
        @(negedge clk);
        cfg_depth = d; cfg_msb_first = msb; cfg_dual = dl;
        in_word = w; in_valid = 1'b1;
        @(posedge clk); #1;
        in_valid = 1'b0;
        if (scramble) begin
            cfg_depth = ~d; cfg_msb_first = ~msb; cfg_dual = ~dl;
        end
        expect_word(tag, w, width_of(d, dl), msb);
        @(negedge clk);
        check({tag, " idle valid R11"}, 32'(pix_valid), 32'd0);
        check({tag, " idle ready R11"}, 32'(in_ready), 32'd1);
    endtask

    // R9: second word held on the input during the first word, taken with no gap
    task automatic run_pair(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        cfg_depth = 2'b10; cfg_msb_first = 1'b0; cfg_dual = 1'b0;
        in_word = a; in_valid = 1'b1;
        @(posedge clk); #1;
        in_word = b;
        expect_word("R9 first word", a, 8, 1'b0);
        @(posedge clk); #1;
        in_valid = 1'b0;
        expect_word("R9 second word", b, 8, 1'b0);
        @(negedge clk);
        check("R9 after pair valid", 32'(pix_valid), 32'd0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset ready", 32'(in_ready), 32'd1);
        check("R1 reset valid", 32'(pix_valid), 32'd0);
        rst_n = 1'b1;
        run_word("R2 nibble lsb", 32'h8765_4321, 2'b01, 1'b0, 1'b0, 0);
        run_word("R3 nibble msb", 32'h8765_4321, 2'b01, 1'b1, 1'b0, 0);
        run_word("R4 byte lsb",   32'hA1B2_C3D4, 2'b10, 1'b0, 1'b0, 0);
        run_word("R4 byte msb",   32'hA1B2_C3D4, 2'b10, 1'b1, 1'b0, 0);
        run_word("R5 half lsb",   32'hBEEF_1234, 2'b11, 1'b0, 1'b0, 0);
        run_word("R5 half msb",   32'hBEEF_1234, 2'b11, 1'b1, 1'b0, 0);
        run_word("R6 mono x4 lsb", 32'hF0E1_D2C3, 2'b00, 1'b0, 1'b0, 0);
        run_word("R6 mono x4 msb", 32'hF0E1_D2C3, 2'b00, 1'b1, 1'b0, 0);
        run_word("R7 mono x8 lsb", 32'h1357_9BDF, 2'b00, 1'b0, 1'b1, 0);
        run_word("R7 mono x8 msb", 32'h1357_9BDF, 2'b00, 1'b1, 1'b1, 0);
        run_word("R8 half dual",  32'hCAFE_0F0F, 2'b11, 1'b0, 1'b1, 0);
        run_word("R8 nibble dual", 32'h0123_4567, 2'b01, 1'b1, 1'b1, 0);
        run_word("R10 mid-word change", 32'h5A6B_7C8D, 2'b01, 1'b0, 1'b0, 1);
        run_pair(32'h1122_3344, 32'h5566_7788);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule